// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programming state of a single DMA channel. It exposes four 32-bit words on a word-wide register bus: a control/status word, a transfer address, a byte count and a base word. Software sets up and starts the channel by writing these words. The block drives three control lines from them:

- a level DMA-enable line for the transfer engine;
- a one-cycle reset strobe for the attached peripheral;
- an interrupt line, which combines an external request with a software enable.

The actual data movement happens elsewhere.

Control writes are not stored verbatim. A write of zero is turned into a flush request. A flush bit written as one is dropped. The top seven bits, together with the three low status bits, keep their old contents apart from a fixed version code, which is always present. Any write to the address word also sets a "loaded" flag in the control word.

A parameter picks between two variants. The standard variant decodes 16 bytes and repeats them through the whole address space. The network variant opens a 32-byte window: the second 16 bytes mirror the first, and anything beyond reads as zero and ignores writes.

The request side is a valid-qualified strobe that the block always takes on the cycle it is presented, so there is no ready line and no back-pressure. A read returns its data with `rsp_valid` one cycle later. The requester must take that response; it cannot stall it.

Top module: `dma_chan_regs`

## Requirements
- R1: While reset is asserted and after it is released, the control word reads 0xA0000000, the other three words read 0, and `irq_o`, `dma_en_o`, `periph_rst_o` and `rsp_valid` are low.
- R2: A read accepted at a clock edge gives `rsp_valid` high for exactly the next cycle, with the word selected by `req_addr[3:2]` (0 control, 1 address, 2 count, 3 base). In the standard variant the four words repeat every 16 bytes.
- R3: On a control write, bits under mask 0xFE000007 keep their stored values, the remaining bits take the written value, and 0xA0000000 is ORed into the result.
- R4: A control write of 0x00000000 is stored as if 0x00000040 (flush request, bit 6) had been written.
- R5: A control write with bit 7 clear and bit 6 set stores bit 6 as zero.
- R6: A control write with bit 7 set drives `periph_rst_o` high for exactly the following cycle, and bit 6 is stored as written. Otherwise `periph_rst_o` stays low.
- R7: `dma_en_o` equals the stored control bit 9. It rises after a control write sets bit 9 while it was clear, and falls after a write clears it.
- R8: A write to the address word (index 1) stores the value and sets control bit 26 (loaded).
- R9: A rising `irq_req_i` sets control bit 0 (pending) and a falling `irq_req_i` clears it. This update is applied after any bus write in the same cycle.
- R10: `irq_o` is high exactly when control bit 0 (pending) and bit 4 (interrupt enable) are both set. It follows writes to bit 4 on the next cycle.
- R11: With `WIDE_WIN=1`, offsets 0x10 to 0x1F alias the four words. Offsets above 0x1F read as 0, and writes to them change nothing: no stored word changes and no reset strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq_req_i | input | 1 | Interrupt request level from the peripheral |
| irq_o | output | 1 | Masked interrupt output |
| periph_rst_o | output | 1 | One-cycle peripheral reset strobe |
| dma_en_o | output | 1 | DMA enable level |

## Verification
The bench builds two instances side by side on the same stimulus: `uut` with `WIDE_WIN=0` and a second one with `WIDE_WIN=1`, both with `ADDR_W=8`. Accesses at offsets 0x14, 0x18, 0x24 and 0x3C therefore land on an aliased word in the standard build, but on a mirrored word or on nothing in the network build. This makes the window edge at 0x1F and the ignored writes beyond it directly comparable against the same write. Interrupt-request edges are placed in the same cycle as control writes, which exposes the ordering of the write and the pending update.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  localparam logic [WORD_W-1:0] VERSION_CODE = 32'hA000_0000;
  localparam logic [WORD_W-1:0] KEEP_MASK    = 32'hFE00_0007;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_FLUSH  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_DIR    = 8;
  localparam int unsigned B_DEN    = 9;
  localparam int unsigned B_LOADED = 26;

  typedef enum logic [IDX_W-1:0] {
    W_CTRL  = 2'd0,
    W_ADDR  = 2'd1,
    W_COUNT = 2'd2,
    W_BASE  = 2'd3
  } word_sel_e;
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          WIDE_WIN = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output word_sel_e         sel,
  output logic              in_win
);
  localparam int unsigned WIN_BITS = WIDE_WIN ? 5 : 4;

  assign sel = word_sel_e'(addr[3:2]);

  generate
    if (WIDE_WIN && (ADDR_W > WIN_BITS)) begin : g_bounded
      assign in_win = ~|addr[ADDR_W-1:WIN_BITS];
    end else begin : g_open
      assign in_win = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dcr_ctrl_fmt.sv
module dcr_ctrl_fmt
  import dcr_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] nxt,
  output logic              prst_req
);
  logic [WORD_W-1:0] shaped;

  always_comb begin
    shaped   = wdata;
    prst_req = wdata[B_PRST];
    if (!wdata[B_PRST]) begin
      if (wdata[B_FLUSH]) begin
        shaped[B_FLUSH] = 1'b0;
      end else if (wdata == '0) begin
        shaped = '0;
        shaped[B_FLUSH] = 1'b1;
      end
    end
    nxt = (cur & KEEP_MASK) | (shaped & ~KEEP_MASK) | VERSION_CODE;
  end
endmodule

// File: rtl/dcr_irq_edge.sv
module dcr_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic set_o,
  output logic clr_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= req_i;
  end

  assign set_o = req_i & ~prev_q;
  assign clr_o = ~req_i & prev_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          WIDE_WIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              periph_rst_o,
  output logic              dma_en_o
);
  word_sel_e         sel;
  logic              in_win;
  logic              wr_hit, rd_hit;
  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [WORD_W-1:0] ctrl_q, ctrl_fmt, ctrl_next;
  logic              prst_req, pend_set, pend_clr;

  dcr_decode #(.ADDR_W(ADDR_W), .WIDE_WIN(WIDE_WIN)) u_dec (
    .addr(req_addr), .sel(sel), .in_win(in_win)
  );

  dcr_ctrl_fmt u_fmt (
    .cur(ctrl_q), .wdata(req_wdata), .nxt(ctrl_fmt), .prst_req(prst_req)
  );

  dcr_irq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i),
    .set_o(pend_set), .clr_o(pend_clr)
  );

  assign wr_hit = req_valid & req_write & in_win;
  assign rd_hit = req_valid & ~req_write;

  // control word: bus write first, then address-load flag, then request edge
  always_comb begin
    ctrl_next = ctrl_q;
    if (wr_hit && sel == W_CTRL) ctrl_next = ctrl_fmt;
    if (wr_hit && sel == W_ADDR) ctrl_next[B_LOADED] = 1'b1;
    if (pend_set)      ctrl_next[B_PEND] = 1'b1;
    else if (pend_clr) ctrl_next[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= VERSION_CODE;
    else        ctrl_q <= ctrl_next;
  end

  assign words_q[0] = ctrl_q;

  generate
    for (genvar i = 1; i < NUM_WORDS; i++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 words_q[i] <= '0;
        else if (wr_hit && sel == word_sel_e'(i))   words_q[i] <= req_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      periph_rst_o <= 1'b0;
    end else begin
      rsp_valid    <= rd_hit;
      if (rd_hit) rsp_rdata <= in_win ? words_q[sel] : '0;
      periph_rst_o <= wr_hit && (sel == W_CTRL) && prst_req;
    end
  end

  assign irq_o    = ctrl_q[B_PEND] & ctrl_q[B_IEN];
  assign dma_en_o = ctrl_q[B_DEN];
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          WIDE_WIN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              irq_req_i,
  input logic              periph_rst_o,
  input logic              dma_en_o,
  input logic [31:0]       ctrl_q
);
  logic live_q;
  logic vis, wctl, waddr, rctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign vis   = !(WIDE_WIN && (int'(req_addr) > 31));
  assign wctl  = req_valid && req_write && vis && (req_addr[3:2] == 2'd0);
  assign waddr = req_valid && req_write && vis && (req_addr[3:2] == 2'd1);
  assign rctl  = req_valid && !req_write && vis && (req_addr[3:2] == 2'd0);

  // R6
  prst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && req_wdata[7]) |=> periph_rst_o);
  // R6
  prst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wctl && req_wdata[7]) |=> !periph_rst_o);
  // R7
  den_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wctl |=> (dma_en_o == $past(req_wdata[9])));
  // R8
  loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waddr |=> ctrl_q[26]);
  // R9
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $rose(irq_req_i)) |=> ctrl_q[0]);
  // R9
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $fell(irq_req_i)) |=> !ctrl_q[0]);
  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (rsp_valid == $past(req_valid && !req_write)));
  // R3
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && rsp_valid && $past(rctl)) |-> (rsp_rdata[31:28] == 4'hA));
endmodule

bind dma_chan_regs dcr_chk #(.ADDR_W(ADDR_W), .WIDE_WIN(WIDE_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq_req_i(irq_req_i), .periph_rst_o(periph_rst_o),
  .dma_en_o(dma_en_o), .ctrl_q(ctrl_q)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, irq_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;

  logic        d_rv [2];
  logic [31:0] d_rd [2];
  logic        d_irq [2], d_prst [2], d_den [2];

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW), .WIDE_WIN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(d_rv[0]),
    .rsp_rdata(d_rd[0]), .irq_req_i(irq_req), .irq_o(d_irq[0]),
    .periph_rst_o(d_prst[0]), .dma_en_o(d_den[0]));

  dma_chan_regs #(.ADDR_W(AW), .WIDE_WIN(1'b1)) uut_net (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(d_rv[1]),
    .rsp_rdata(d_rd[1]), .irq_req_i(irq_req), .irq_o(d_irq[1]),
    .periph_rst_o(d_prst[1]), .dma_en_o(d_den[1]));

  // behavioural reference state, index 0 = standard, 1 = network
  logic [31:0] m_w [2][4];
  logic        m_prev [2];
  logic        m_rv [2], m_prst [2];
  logic [31:0] m_rd [2];

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_w[v][0] = 32'hA000_0000;
        for (int k = 1; k < 4; k++) m_w[v][k] = 0;
        m_prev[v] = 0; m_rv[v] = 0; m_rd[v] = 0; m_prst[v] = 0;
      end else begin
        int a = int'(req_addr);
        bit vis = !(v == 1 && a > 31);
        int idx = (a / 4) % 4;
        m_prst[v] = 0;
        m_rv[v] = req_valid && !req_write;
        if (m_rv[v]) m_rd[v] = vis ? m_w[v][idx] : 32'h0;
        if (req_valid && req_write && vis) begin
          if (idx == 0) begin
            logic [31:0] val = req_wdata;
            if (val[7]) m_prst[v] = 1;
            else if (val[6]) val[6] = 0;
            else if (val == 0) val = 32'h40;
            m_w[v][0] = (m_w[v][0] & 32'hFE00_0007) | (val & ~32'hFE00_0007) | 32'hA000_0000;
          end else begin
            m_w[v][idx] = req_wdata;
            if (idx == 1) m_w[v][0][26] = 1'b1;
          end
        end
        if (irq_req && !m_prev[v]) m_w[v][0][0] = 1'b1;
        else if (!irq_req && m_prev[v]) m_w[v][0][0] = 1'b0;
        m_prev[v] = irq_req;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!done) begin
      cyc++;
      model_step();
      #(CLK_P/4);
      for (int v = 0; v < 2; v++) begin
        check(d_rv[v] === m_rv[v], v ? "net rsp_valid (R2)" : "std rsp_valid (R2)", 32'(d_rv[v]), 32'(m_rv[v]));
        if (m_rv[v])
          check(d_rd[v] === m_rd[v], v ? "net rsp_rdata" : "std rsp_rdata", d_rd[v], m_rd[v]);
        check(d_prst[v] === m_prst[v], "periph_rst_o (R6)", 32'(d_prst[v]), 32'(m_prst[v]));
        check(d_den[v] === m_w[v][0][9], "dma_en_o (R7)", 32'(d_den[v]), 32'(m_w[v][0][9]));
        check(d_irq[v] === (m_w[v][0][0] & m_w[v][0][4]), "irq_o (R10)", 32'(d_irq[v]),
              32'(m_w[v][0][0] & m_w[v][0][4]));
      end
      if (cyc > 5000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<=5000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input string t);
    @(negedge clk);
    tag = t; req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, input string t);
    @(negedge clk);
    tag = t; req_valid = 1; req_write = 0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic irq_set(input logic l, input string t);
    @(negedge clk);
    tag = t; irq_req = l;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(0, "R1"); rd(4, "R1"); rd(8, "R1"); rd(12, "R1");
    // R4 zero write becomes flush
    wr(0, 32'h0, "R4"); rd(0, "R4");
    // R5 flush bit dropped
    wr(0, 32'h0000_0050, "R5"); rd(0, "R5");
    // R3 R6 all ones: reset strobe, kept bits, flush kept
    wr(0, 32'hFFFF_FFFF, "R3_R6"); rd(0, "R3"); rd(0, "R6");
    // R7 enable toggles
    wr(0, 32'h0000_0200, "R7"); rd(0, "R7");
    wr(0, 32'h0000_0000, "R7"); rd(0, "R7");
    // R8 address load
    wr(4, 32'h1234_5678, "R8"); rd(0, "R8"); rd(4, "R8");
    // R2 aliasing
    wr(8, 32'h0000_0100, "R2"); wr(12, 32'hCAFE_0010, "R2");
    rd(8, "R2"); rd(24, "R2"); rd(28, "R2"); rd(20, "R2");
    // R9 R10 interrupt path
    wr(0, 32'h0000_0010, "R10");
    irq_set(1, "R9"); rd(0, "R9");
    irq_set(0, "R9"); rd(0, "R9");
    irq_set(1, "R10"); wr(0, 32'h0000_0200, "R10"); rd(0, "R10");
    wr(0, 32'h0000_0210, "R10");
    // same-cycle write and falling request
    @(negedge clk); tag = "R9"; irq_req = 0; req_valid = 1; req_write = 1;
    req_addr = 0; req_wdata = 32'h0000_0011;
    @(negedge clk); req_valid = 0; req_write = 0;
    rd(0, "R9");
    // R11 window limits
    wr(36, 32'hDEAD_BEEF, "R11"); rd(36, "R11"); rd(4, "R11");
    wr(32, 32'h0000_0080, "R11"); rd(32, "R11");
    wr(60, 32'h5555_AAAA, "R11"); rd(12, "R11"); rd(28, "R11");
    wr(16, 32'h0000_0000, "R11"); rd(0, "R11"); rd(255, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule